// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block is a bus slave that keeps a bank of one-bit semaphores so that several processors on a chip can take turns using shared resources. Each semaphore has its own 32-bit word in the address map. To take a semaphore, a requester reads its word. The read returns the earlier state and leaves the semaphore set, all in one step. A returned 0 means the requester now owns the semaphore. A returned 1 means someone else owns it and the requester has to try again later. The owner gives the semaphore back by writing zero to the same word.

The bank has one or more request ports, one port for each attached master. Every port takes one access per cycle. Read data comes back exactly one cycle later, and a port is never stalled. Accesses to the same semaphore in the same cycle are handled in port order, and the lowest-numbered port goes first. A read-only identification word tells software how many semaphores the bank holds. The bank size is chosen when the block is built.

Top module: `hw_semaphore_bank`

## Requirements
- R1: After reset every semaphore is free and no read response is pending. rvalid_o stays low while rst_n is low.
- R2: A read of a free semaphore returns the word 0x0000_0000 and marks the semaphore owned, so the next read of it returns 1.
- R3: A read of an owned semaphore returns 0x0000_0001 and leaves it owned.
- R4: A write of 0x0000_0000 to a semaphore word frees it, so the next read returns 0.
- R5: A write of any nonzero value to a semaphore word has no effect on that semaphore.
- R6: A read of byte address 0x014 returns the identification word. Bits 27:24 hold the one-hot code NUM_LOCKS/32 (1, 2, 4 or 8), and every other bit is 0. Writes to this word have no effect.
- R7: Semaphore k (0 ≤ k < NUM_LOCKS) lives at byte address 0x800 + 4·k.
- R8: Any other address is unmapped. This includes unaligned addresses inside the semaphore window and addresses past the last semaphore. A read of an unmapped address returns 0, and neither reads nor writes there change any semaphore.
- R9: Accesses to one semaphore in the same cycle take effect in ascending port order. When several ports read a free semaphore together, only the lowest-numbered one gets 0. A read ordered before a release sees the earlier state, and a read ordered after a release sees 0.
- R10: Every read, mapped or not, raises rvalid_o on its port exactly one cycle later with the data. Writes and idle cycles produce no rvalid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_PORTS | Access request, one bit per port |
| we_i | input | NUM_PORTS | 1 = write, 0 = read, per port |
| addr_i | input | NUM_PORTS × ADDR_W | Byte address per port |
| wdata_i | input | NUM_PORTS × 32 | Write data per port |
| rvalid_o | output | NUM_PORTS | Read data valid, one cycle after a read |
| rdata_o | output | NUM_PORTS × 32 | Read data per port |

## Verification
The assertions check the following on every cycle:
- Two ports never both win the same free semaphore.
- A held semaphore stays held unless a zero write reaches it.
- A read always leaves its semaphore owned.
- Cycles without semaphore traffic leave the bank untouched.
- The response timing, the identification word and the zeros returned for unmapped reads are always as specified.

Only the bench scenarios can show the end-to-end meaning of the returned values. These scenarios cover the full take and release history of every semaphore, and writes of nonzero values and writes to aliasing unaligned addresses that must not disturb an owner. They also cover the two orders in which a read and a release of the same semaphore can meet in one cycle.

// File: rtl/spl_pkg.sv
package spl_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned BANK_BASE = 'h800;
   localparam int unsigned ID_OFS    = 'h14;
   localparam int unsigned CNT_LSB   = 24;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_LOCK = 2'd1,
      HIT_ID   = 2'd2
   } hit_e;

   function automatic logic [3:0] size_code(input int unsigned n);
      return 4'(n / 32);
   endfunction
endpackage

// File: rtl/spl_decode.sv
module spl_decode #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_LOCKS = 32,
   localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
   input  logic [ADDR_W-1:0] addr,
   output spl_pkg::hit_e     hit,
   output logic [IDX_W-1:0]  idx
);
   import spl_pkg::*;

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BANK_BASE);
   localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_OFS);
   localparam logic [ADDR_W-1:0] LIM_W  = ADDR_W'(NUM_LOCKS);

   logic [ADDR_W-1:0] rel;
   logic [ADDR_W-1:0] word;

   assign rel  = addr - BASE_A;
   assign word = rel >> 2;

   always_comb begin
      hit = HIT_NONE;
      idx = '0;
      if (addr == ID_A) begin
         hit = HIT_ID;
      end else if (addr >= BASE_A && rel[1:0] == 2'b00 && word < LIM_W) begin
         hit = HIT_LOCK;
         idx = word[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/spl_lock_core.sv
module spl_lock_core #(
   parameter int unsigned NUM_LOCKS = 32,
   parameter int unsigned NUM_PORTS = 2,
   localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_PORTS-1:0]              rd_lock,
   input  logic [NUM_PORTS-1:0]              rel_lock,
   input  logic [NUM_PORTS-1:0][IDX_W-1:0]   idx,
   output logic [NUM_PORTS-1:0]              prior
);
   logic [NUM_LOCKS-1:0] lock_q;
   logic [NUM_LOCKS-1:0] lock_d;

   // Ports are applied one after another; lower index acts first.
   always_comb begin
      lock_d = lock_q;
      prior  = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (rd_lock[p]) begin
            prior[p]       = lock_d[idx[p]];
            lock_d[idx[p]] = 1'b1;
         end else if (rel_lock[p]) begin
            lock_d[idx[p]] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= lock_d;
   end

   // ---- checks ----
   logic [NUM_LOCKS-1:0] rd_vec, rel_vec;
   always_comb begin
      rd_vec  = '0;
      rel_vec = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (rd_lock[p])  rd_vec[idx[p]]  = 1'b1;
         if (rel_lock[p]) rel_vec[idx[p]] = 1'b1;
      end
   end

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lock == '0 && rel_lock == '0) |=> $stable(lock_q));

   for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_lk
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (lock_q[k] && !rel_vec[k]) |=> lock_q[k]);
      p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_vec[k] && !rel_vec[k]) |=> lock_q[k]);
   end

   for (genvar a = 0; a < NUM_PORTS; a++) begin : g_pa
      for (genvar b = a + 1; b < NUM_PORTS; b++) begin : g_pb
         p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_lock[a] && rd_lock[b] && idx[a] == idx[b]) |-> (prior[a] || prior[b]));
      end
   end
endmodule

// File: rtl/spl_rdret.sv
module spl_rdret #(
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned NUM_LOCKS = 32
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [NUM_PORTS-1:0]                       rd_any,
   input  logic [NUM_PORTS-1:0]                       rd_id,
   input  logic [NUM_PORTS-1:0]                       rd_lock,
   input  logic [NUM_PORTS-1:0]                       prior,
   output logic [NUM_PORTS-1:0]                       rvalid,
   output logic [NUM_PORTS-1:0][spl_pkg::WORD_W-1:0]  rdata
);
   import spl_pkg::*;

   localparam logic [WORD_W-1:0] ID_WORD = WORD_W'(size_code(NUM_LOCKS)) << CNT_LSB;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rvalid[p] <= 1'b0;
            rdata[p]  <= '0;
         end else begin
            rvalid[p] <= rd_any[p];
            if (rd_id[p])        rdata[p] <= ID_WORD;
            else if (rd_lock[p]) rdata[p] <= {{(WORD_W-1){1'b0}}, prior[p]};
            else                 rdata[p] <= '0;
         end
      end

      p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
         rd_any[p] |=> rvalid[p]);
      p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_any[p] |=> !rvalid[p]);
      p_id_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
         rd_id[p] |=> (rdata[p][CNT_LSB +: 4] == size_code(NUM_LOCKS)
                       && $countones(rdata[p]) == 1));
      p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_any[p] && !rd_id[p] && !rd_lock[p]) |=> rdata[p] == '0);
   end
endmodule

// File: rtl/hw_semaphore_bank.sv
module hw_semaphore_bank #(
   parameter int unsigned NUM_LOCKS = 32,
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned ADDR_W    = 12
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [NUM_PORTS-1:0]                       req_i,
   input  logic [NUM_PORTS-1:0]                       we_i,
   input  logic [NUM_PORTS-1:0][ADDR_W-1:0]           addr_i,
   input  logic [NUM_PORTS-1:0][spl_pkg::WORD_W-1:0]  wdata_i,
   output logic [NUM_PORTS-1:0]                       rvalid_o,
   output logic [NUM_PORTS-1:0][spl_pkg::WORD_W-1:0]  rdata_o
);
   import spl_pkg::*;

   localparam int unsigned IDX_W = $clog2(NUM_LOCKS);

   if (!(NUM_LOCKS == 32 || NUM_LOCKS == 64 || NUM_LOCKS == 128 || NUM_LOCKS == 256))
   begin : g_bad_size
      $error("NUM_LOCKS must be 32, 64, 128 or 256");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end

   hit_e [NUM_PORTS-1:0]            hit;
   logic [NUM_PORTS-1:0][IDX_W-1:0] idx;
   logic [NUM_PORTS-1:0]            rd_any, rd_id, rd_lock, rel_lock, prior;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
      spl_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) u_dec (
         .addr (addr_i[p]),
         .hit  (hit[p]),
         .idx  (idx[p])
      );
      assign rd_any[p]   = req_i[p] && !we_i[p];
      assign rd_id[p]    = rd_any[p] && hit[p] == HIT_ID;
      assign rd_lock[p]  = rd_any[p] && hit[p] == HIT_LOCK;
      assign rel_lock[p] = req_i[p] && we_i[p] && hit[p] == HIT_LOCK && wdata_i[p] == '0;
   end

   spl_lock_core #(.NUM_LOCKS(NUM_LOCKS), .NUM_PORTS(NUM_PORTS)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_lock  (rd_lock),
      .rel_lock (rel_lock),
      .idx      (idx),
      .prior    (prior)
   );

   spl_rdret #(.NUM_PORTS(NUM_PORTS), .NUM_LOCKS(NUM_LOCKS)) u_ret (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_any  (rd_any),
      .rd_id   (rd_id),
      .rd_lock (rd_lock),
      .prior   (prior),
      .rvalid  (rvalid_o),
      .rdata   (rdata_o)
   );
endmodule

// File: tb/hw_semaphore_bank_test.sv
module hw_semaphore_bank_test;
   localparam int NL = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]        req = '0, we = '0;
   logic [1:0][11:0]  addr = '0;
   logic [1:0][31:0]  wdata = '0;
   logic [1:0]        rvalid;
   logic [1:0][31:0]  rdata;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   typedef struct { logic [31:0] v; string tag; } exp_t;
   exp_t q0[$];
   exp_t q1[$];

   always #5 clk = ~clk;

   hw_semaphore_bank #(.NUM_LOCKS(NL), .NUM_PORTS(2), .ADDR_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we),
      .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata)
   );

   function automatic logic [11:0] lk(input int k);
      return 12'(12'h800 + 4 * k);
   endfunction

   task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input int p, input logic w, input logic [11:0] a,
                      input logic [31:0] d, input logic [31:0] e, input string tag);
      exp_t it;
      req[p] = 1'b1; we[p] = w; addr[p] = a; wdata[p] = d;
      if (!w) begin
         it.v = e; it.tag = tag;
         if (p == 0) q0.push_back(it); else q1.push_back(it);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      req = '0; we = '0;
   endtask

   // monitor: pops expected read data as responses appear (R10 timing)
   always @(negedge clk) begin
      if (rst_n) begin
         if (rvalid[0]) begin
            if (q0.size() == 0) cmp(32'h1, 32'h0, "R10 port0 unexpected rvalid");
            else begin exp_t e0; e0 = q0.pop_front(); cmp(rdata[0], e0.v, e0.tag); end
         end else if (q0.size() != 0 && q0[0].tag != "")
            ;
         if (rvalid[1]) begin
            if (q1.size() == 0) cmp(32'h1, 32'h0, "R10 port1 unexpected rvalid");
            else begin exp_t e1; e1 = q1.pop_front(); cmp(rdata[1], e1.v, e1.tag); end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp({31'b0, rvalid[0] | rvalid[1]}, 32'h0, "R1 rvalid low in reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2: every semaphore starts free; first read takes it
      for (int k = 0; k < NL; k++) begin put(0, 0, lk(k), 0, 0, "R1 R2 first read free"); tick(); end
      // R3: second read sees owned
      for (int k = 0; k < NL; k++) begin put(1, 0, lk(k), 0, 1, "R3 owned read"); tick(); end
      put(0, 0, lk(7), 0, 1, "R3 stays owned"); tick();

      // R4: zero write frees
      put(0, 1, lk(5), 0, 0, ""); tick();
      put(1, 0, lk(5), 0, 0, "R4 freed reads 0"); tick();
      // R5: nonzero write ignored
      put(0, 1, lk(6), 32'h1, 0, ""); tick();
      put(0, 1, lk(6), 32'h8000_0000, 0, ""); tick();
      put(0, 0, lk(6), 0, 1, "R5 nonzero write ignored"); tick();

      // R6: identification word, read-only
      put(0, 0, 12'h014, 0, 32'h0100_0000, "R6 id word"); tick();
      put(0, 1, 12'h014, 0, 0, ""); tick();
      put(1, 0, 12'h014, 0, 32'h0100_0000, "R6 id after write"); tick();

      // R8: unmapped reads/writes; lock 0 owned must survive an aliasing zero write
      put(0, 1, 12'h802, 0, 0, ""); tick();
      put(0, 1, lk(NL), 0, 0, ""); tick();
      put(0, 0, lk(0), 0, 1, "R8 unaligned write no effect"); tick();
      // release all
      for (int k = 0; k < NL; k++) begin put(1, 1, lk(k), 0, 0, ""); tick(); end
      put(0, 0, 12'h802, 0, 0, "R8 unaligned read returns 0"); tick();
      put(0, 0, lk(0), 0, 0, "R8 unaligned read took nothing"); tick();
      put(0, 0, lk(NL), 0, 0, "R8 past-end read returns 0"); tick();
      put(0, 0, 12'h000, 0, 0, "R8 offset 0 returns 0"); tick();

      // R7: last semaphore at its own address
      put(0, 0, 12'h87C, 0, 0, "R7 last word free"); tick();
      put(1, 0, 12'h87C, 0, 1, "R7 last word owned"); tick();
      put(0, 0, lk(30), 0, 0, "R7 neighbour untouched"); tick();

      // R9: same-cycle contention
      put(0, 0, lk(3), 0, 0, "R9 port0 wins");
      put(1, 0, lk(3), 0, 1, "R9 port1 loses"); tick();
      put(0, 0, lk(4), 0, 0, "R9 distinct locks p0");
      put(1, 0, lk(2), 0, 0, "R9 distinct locks p1"); tick();
      put(0, 0, lk(3), 0, 1, "R9 read before release sees owned");
      put(1, 1, lk(3), 0, 0, ""); tick();
      put(0, 0, lk(3), 0, 0, "R9 freed by port1"); tick();
      put(0, 1, lk(3), 0, 0, "");
      put(1, 0, lk(3), 0, 0, "R9 read after release sees free"); tick();
      put(0, 0, lk(3), 0, 1, "R9 port1 kept it"); tick();

      // R10: writes produce no response; all expected responses drained
      put(0, 1, lk(9), 0, 0, ""); put(1, 1, lk(9), 0, 0, ""); tick();
      tick(); tick();
      cmp(32'(q0.size() + q1.size()), 0, "R10 all responses delivered");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule